// File: doc/BRIEF.md
# Register-Mapped SPI Master with Byte FIFOs

This block is an SPI bus master driven by software through a small word-addressed register window. Software queues 8-bit frames in a transmit FIFO and then lets the shifter run. Every frame sent on the serial lines brings one received byte back into a receive FIFO, and software drains that FIFO through a data register. A hold bit in the control word keeps the shifter idle while a burst is being queued. Clearing the hold bit lets the queued bytes go out back to back, in the order they were written.

The serial clock is the system clock divided by a fixed parameter. Clock polarity, clock phase, bit order and an internal loopback path are chosen in the control word. The slave-select lines are active low and come from a register that software writes. In manual mode the lines follow that register at all times; otherwise they follow it only while a frame is in flight. Writing a fixed key value to a reset register returns every register and both FIFOs to their power-up state. Three interrupt-related words exist only as plain read/write storage.

Top module: `spi_fifo_master`

## Requirements
- R1: After reset, the control word (0x60) reads 0x180 and the status word (0x64) reads 0x25: bit0 receive empty, bit1 receive full, bit2 transmit empty, bit3 transmit full, bit4 mode fault (always 0), bit5 fixed at 1. All select lines are high and SCLK sits low.
- R2: Writing exactly 0x0A to 0x40 returns the control word, the select register, the storage words and both FIFOs to their reset state and stops any frame in flight. Any other value written there changes nothing.
- R3: While control bit8 (hold) is set, SCLK does not toggle, even with bytes queued.
- R4: With hold clear and control bits 1 (enable) and 2 (master) set, queued bytes are shifted out in write order with no software action between frames.
- R5: Only bits 7:0 of a write to 0x68 are queued. A read of 0x6C returns the oldest received byte in bits 7:0, with bits 31:8 zero, and removes it from the FIFO.
- R6: Status bit3 is set exactly when the transmit FIFO holds DEPTH bytes. A write to 0x68 while the FIFO is full is dropped.
- R7: Status bit2 is set only when the transmit FIFO is empty and no frame is in flight.
- R8: Each completed frame pushes one byte into the receive FIFO, and status bit0 clears. With control bit0 (loopback) set, the received byte equals the sent byte.
- R9: Writing control bit5 empties the transmit FIFO, and writing control bit6 empties the receive FIFO. Both bits read back as 0.
- R10: The select lines follow the select register (0x70, active low, bit n drives line n). With control bit7 set they follow it at all times. With bit7 clear they follow it only while a frame is in flight and are all high otherwise.
- R11: Control bit3 (CPOL) sets the idle SCLK level. With control bit4 (CPHA) clear, data is sampled on the first edge of each bit; with it set, on the second edge. MISO data sent by a slave in that mode is received correctly.
- R12: With control bit9 set, the least significant bit is sent first and the first received bit lands in bit 0.
- R13: Registers 0x74 and 0x78 read the transmit and receive FIFO entry count minus one, or 0 when the FIFO is empty.
- R14: The words at 0x1C, 0x20 and 0x28 read back the last value written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe, one cycle per write |
| regRdEn | input | 1 | Register read strobe; pops the receive FIFO when addressing 0x6C |
| regAddr | input | 7 | Byte address of the register word |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data, combinational from the address |
| spiSclk | output | 1 | Serial clock |
| spiMosi | output | 1 | Serial data out, high when idle |
| spiMiso | input | 1 | Serial data in |
| spiSsN | output | NUM_SS | Active-low slave selects |

## Verification
The assertions take two things for granted. First, software writes the select register with at most one line low. Second, polarity, phase, bit order and loopback are changed only while no frame is in flight. The stimulus keeps to both: every mode change happens with the hold bit set and the transmit FIFO drained, with all selects high. Only the one-hot and all-ones select patterns are ever written. A bench-side slave model samples MOSI and drives MISO on the edges that the programmed mode dictates, so the byte seen on the wire and the byte read back are both compared against values the bench predicts itself.

// File: rtl/spi_fifo_pkg.sv
package spi_fifo_pkg;

  localparam int REG_AW = 7;

  localparam logic [REG_AW-1:0] ADR_GIE   = 7'h1C;
  localparam logic [REG_AW-1:0] ADR_ISR   = 7'h20;
  localparam logic [REG_AW-1:0] ADR_IER   = 7'h28;
  localparam logic [REG_AW-1:0] ADR_RST   = 7'h40;
  localparam logic [REG_AW-1:0] ADR_CTRL  = 7'h60;
  localparam logic [REG_AW-1:0] ADR_STAT  = 7'h64;
  localparam logic [REG_AW-1:0] ADR_TXD   = 7'h68;
  localparam logic [REG_AW-1:0] ADR_RXD   = 7'h6C;
  localparam logic [REG_AW-1:0] ADR_SS    = 7'h70;
  localparam logic [REG_AW-1:0] ADR_TXOCC = 7'h74;
  localparam logic [REG_AW-1:0] ADR_RXOCC = 7'h78;

  localparam logic [31:0] RST_KEY = 32'h0000_000A;

  localparam int CTRL_W = 10;
  localparam logic [CTRL_W-1:0] CTRL_RST     = 10'h180;
  localparam logic [CTRL_W-1:0] CTRL_SELFCLR = 10'h060;

  localparam int CB_LOOP  = 0;
  localparam int CB_EN    = 1;
  localparam int CB_MSTR  = 2;
  localparam int CB_CPOL  = 3;
  localparam int CB_CPHA  = 4;
  localparam int CB_TXCLR = 5;
  localparam int CB_RXCLR = 6;
  localparam int CB_MANSS = 7;
  localparam int CB_HOLD  = 8;
  localparam int CB_LSB   = 9;

  // strobes and frame configuration from control to datapath
  typedef struct packed {
    logic load;
    logic abort;
    logic cpol;
    logic cpha;
    logic lsbFirst;
    logic loop;
  } dpCmd_t;

endpackage

// File: rtl/spi_fifo_buf.sv
module spi_fifo_buf #(
  parameter int DEPTH = 16,
  parameter int W     = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clr,
  input  logic             push,
  input  logic [W-1:0]     din,
  input  logic             pop,
  output logic [W-1:0]     dout,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             empty
);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic             doPush, doPop;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full   = (count == CNT_W'(DEPTH));
  assign empty  = (count == '0);
  assign doPush = push && !full;
  assign doPop  = pop && !empty;
  assign dout   = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (doPush && !clr) mem[wrPtr] <= din;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else if (clr) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= nextPtr(wrPtr);
      if (doPop)  rdPtr <= nextPtr(rdPtr);
      if (doPush && !doPop)      count <= count + 1'b1;
      else if (doPop && !doPush) count <= count - 1'b1;
    end
  end

  // R6
  drop_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    full && push && !pop && !clr |=> count == CNT_W'(DEPTH));

  // R5
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rstN)
    empty && pop && !push && !clr |=> empty);

endmodule

// File: rtl/spi_fifo_ctrl.sv
module spi_fifo_ctrl
  import spi_fifo_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int NUM_SS = 4,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  input  logic              txFull,
  input  logic              txEmpty,
  input  logic [CNT_W-1:0]  txCount,
  input  logic              rxFull,
  input  logic              rxEmpty,
  input  logic [CNT_W-1:0]  rxCount,
  input  logic [7:0]        rxHead,
  input  logic              dpBusy,
  input  logic              dpDone,
  output logic              txPush,
  output logic              txPop,
  output logic              txClr,
  output logic              rxPush,
  output logic              rxPop,
  output logic              rxClr,
  output dpCmd_t            cmd,
  output logic [NUM_SS-1:0] ssN
);

  logic [CTRL_W-1:0] ctrlReg;
  logic [NUM_SS-1:0] ssReg;
  logic [31:0]       gieReg, isrReg, ierReg;
  logic              swReset, ctrlWr, runOk, txIdle;

  function automatic logic [31:0] occ(input logic [CNT_W-1:0] c);
    return (c == '0) ? 32'd0 : 32'(c) - 32'd1;
  endfunction

  assign swReset = regWrEn && (regAddr == ADR_RST) && (regWrData == RST_KEY);
  assign ctrlWr  = regWrEn && (regAddr == ADR_CTRL);
  assign txClr   = swReset || (ctrlWr && regWrData[CB_TXCLR]);
  assign rxClr   = swReset || (ctrlWr && regWrData[CB_RXCLR]);
  assign txPush  = regWrEn && (regAddr == ADR_TXD) && !txFull;
  assign rxPop   = regRdEn && (regAddr == ADR_RXD) && !rxEmpty;
  assign rxPush  = dpDone && !rxFull;
  assign runOk   = ctrlReg[CB_EN] && ctrlReg[CB_MSTR] && !ctrlReg[CB_HOLD];
  assign txIdle  = txEmpty && !dpBusy;

  always_comb begin
    cmd.load     = runOk && !txEmpty && !dpBusy && !txClr;
    cmd.abort    = swReset;
    cmd.cpol     = ctrlReg[CB_CPOL];
    cmd.cpha     = ctrlReg[CB_CPHA];
    cmd.lsbFirst = ctrlReg[CB_LSB];
    cmd.loop     = ctrlReg[CB_LOOP];
  end
  assign txPop = cmd.load;

  assign ssN = (ctrlReg[CB_MANSS] || dpBusy) ? ssReg : '1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg <= CTRL_RST;
      ssReg   <= '1;
      gieReg  <= '0;
      isrReg  <= '0;
      ierReg  <= '0;
    end else if (swReset) begin
      ctrlReg <= CTRL_RST;
      ssReg   <= '1;
      gieReg  <= '0;
      isrReg  <= '0;
      ierReg  <= '0;
    end else if (regWrEn) begin
      case (regAddr)
        ADR_CTRL: ctrlReg <= regWrData[CTRL_W-1:0] & ~CTRL_SELFCLR;
        ADR_SS:   ssReg   <= regWrData[NUM_SS-1:0];
        ADR_GIE:  gieReg  <= regWrData;
        ADR_ISR:  isrReg  <= regWrData;
        ADR_IER:  ierReg  <= regWrData;
        default:  ;
      endcase
    end
  end

  always_comb begin
    case (regAddr)
      ADR_GIE:   regRdData = gieReg;
      ADR_ISR:   regRdData = isrReg;
      ADR_IER:   regRdData = ierReg;
      ADR_CTRL:  regRdData = 32'(ctrlReg);
      ADR_STAT:  regRdData = {26'd0, 1'b1, 1'b0, txFull, txIdle, rxFull, rxEmpty};
      ADR_RXD:   regRdData = rxEmpty ? 32'd0 : {24'd0, rxHead};
      ADR_SS:    regRdData = 32'(ssReg);
      ADR_TXOCC: regRdData = occ(txCount);
      ADR_RXOCC: regRdData = occ(rxCount);
      default:   regRdData = 32'd0;
    endcase
  end

  // R3
  inhibit_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrlReg[CB_HOLD] && !dpBusy |=> !dpBusy);

  // R2
  soft_reset_chk: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn && regAddr == ADR_RST && regWrData == RST_KEY
    |=> ctrlReg == CTRL_RST && ssReg == '1 && txEmpty && rxEmpty);

  // R8
  rx_push_chk: assert property (@(posedge clk) disable iff (!rstN)
    dpDone && !rxFull && !rxClr |=> !rxEmpty);

  // R10
  ss_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~ssN));

endmodule

// File: rtl/spi_fifo_dp.sv
module spi_fifo_dp
  import spi_fifo_pkg::*;
#(
  parameter int HALF_DIV = 2,
  localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1
) (
  input  logic       clk,
  input  logic       rstN,
  input  dpCmd_t     cmd,
  input  logic [7:0] txByte,
  input  logic       miso,
  output logic       busy,
  output logic       done,
  output logic [7:0] rxByte,
  output logic       sclk,
  output logic       mosi
);

  logic [DIV_W-1:0] divCnt;
  logic [3:0]       edgeCnt;
  logic [7:0]       txSh, rxSh, rxNext;
  logic             tick, isSample, isShift, outBit, inBit, lastEdge;

  assign tick     = busy && (divCnt == DIV_W'(HALF_DIV - 1));
  assign lastEdge = (edgeCnt == 4'd15);
  assign isSample = (edgeCnt[0] == cmd.cpha);
  assign isShift  = !isSample && !(cmd.cpha && edgeCnt == 4'd0);
  assign outBit   = cmd.lsbFirst ? txSh[0] : txSh[7];
  assign inBit    = cmd.loop ? outBit : miso;
  assign rxNext   = cmd.lsbFirst ? {inBit, rxSh[7:1]} : {rxSh[6:0], inBit};
  assign done     = tick && lastEdge;
  assign rxByte   = isSample ? rxNext : rxSh;
  assign mosi     = busy ? outBit : 1'b1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy    <= 1'b0;
      sclk    <= 1'b0;
      divCnt  <= '0;
      edgeCnt <= '0;
      txSh    <= '0;
      rxSh    <= '0;
    end else if (cmd.abort) begin
      busy    <= 1'b0;
      sclk    <= cmd.cpol;
      divCnt  <= '0;
      edgeCnt <= '0;
    end else if (cmd.load) begin
      busy    <= 1'b1;
      sclk    <= cmd.cpol;
      divCnt  <= '0;
      edgeCnt <= '0;
      txSh    <= txByte;
    end else if (busy) begin
      divCnt <= tick ? '0 : divCnt + 1'b1;
      if (tick) begin
        sclk    <= ~sclk;
        edgeCnt <= edgeCnt + 1'b1;
        if (isSample) rxSh <= rxNext;
        if (isShift)  txSh <= cmd.lsbFirst ? {1'b0, txSh[7:1]} : {txSh[6:0], 1'b0};
        if (lastEdge) busy <= 1'b0;
      end
    end else begin
      sclk <= cmd.cpol;
    end
  end

  // R11
  idle_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy && $stable(cmd.cpol) |-> sclk == cmd.cpol);

  // R8
  frame_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !busy);

endmodule

// File: rtl/spi_fifo_master.sv
module spi_fifo_master
  import spi_fifo_pkg::*;
#(
  parameter int DEPTH    = 16,
  parameter int HALF_DIV = 2,
  parameter int NUM_SS   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [6:0]        regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  output logic              spiSclk,
  output logic              spiMosi,
  input  logic              spiMiso,
  output logic [NUM_SS-1:0] spiSsN
);

  localparam int CNT_W = $clog2(DEPTH + 1);

  dpCmd_t           cmd;
  logic             txPush, txPop, txClr, rxPush, rxPop, rxClr;
  logic             txFull, txEmpty, rxFull, rxEmpty;
  logic [CNT_W-1:0] txCount, rxCount;
  logic [7:0]       txHead, rxHead, dpRxByte;
  logic             dpBusy, dpDone;

  spi_fifo_buf #(.DEPTH(DEPTH), .W(8)) u_txFifo (
    .clk(clk), .rstN(rstN), .clr(txClr), .push(txPush), .din(regWrData[7:0]),
    .pop(txPop), .dout(txHead), .count(txCount), .full(txFull), .empty(txEmpty));

  spi_fifo_buf #(.DEPTH(DEPTH), .W(8)) u_rxFifo (
    .clk(clk), .rstN(rstN), .clr(rxClr), .push(rxPush), .din(dpRxByte),
    .pop(rxPop), .dout(rxHead), .count(rxCount), .full(rxFull), .empty(rxEmpty));

  spi_fifo_ctrl #(.DEPTH(DEPTH), .NUM_SS(NUM_SS)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .txFull(txFull), .txEmpty(txEmpty), .txCount(txCount),
    .rxFull(rxFull), .rxEmpty(rxEmpty), .rxCount(rxCount), .rxHead(rxHead),
    .dpBusy(dpBusy), .dpDone(dpDone),
    .txPush(txPush), .txPop(txPop), .txClr(txClr),
    .rxPush(rxPush), .rxPop(rxPop), .rxClr(rxClr),
    .cmd(cmd), .ssN(spiSsN));

  spi_fifo_dp #(.HALF_DIV(HALF_DIV)) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .txByte(txHead), .miso(spiMiso),
    .busy(dpBusy), .done(dpDone), .rxByte(dpRxByte),
    .sclk(spiSclk), .mosi(spiMosi));

endmodule

// File: tb/spi_fifo_master_bench.sv
`timescale 1ns/1ps
module spi_fifo_master_bench;

  localparam int DEPTH  = 8;
  localparam int NUM_SS = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0, regRdEn = 1'b0;
  logic [6:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        spiSclk, spiMosi;
  logic        spiMiso = 1'b0;
  logic [NUM_SS-1:0] spiSsN;

  int checks = 0, fails = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  spi_fifo_master #(.DEPTH(DEPTH), .HALF_DIV(2), .NUM_SS(NUM_SS)) u_spi_fifo_master (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .spiSclk(spiSclk), .spiMosi(spiMosi), .spiMiso(spiMiso), .spiSsN(spiSsN));

  // slave model and wire monitor
  logic       monCpol = 1'b0, monCpha = 1'b0;
  logic [7:0] slavePatt = 8'h00;
  logic [7:0] monSh = '0;
  logic [7:0] monBytes [16];
  int         monNum = 0, monCnt = 0, sclkEdges = 0;
  logic       prevSclk = 1'b0;
  logic       lead;

  always @(spiSclk or spiSsN or slavePatt) begin
    if (spiSsN == '1) begin
      monCnt  = 0;
      spiMiso = slavePatt[7];
    end else if (spiSclk !== prevSclk) begin
      lead = (spiSclk != monCpol);
      if (lead != monCpha) begin
        monSh = {monSh[6:0], spiMosi};
        monCnt++;
        if (monCnt == 8) begin
          if (monNum < 16) monBytes[monNum] = monSh;
          monNum++;
          monCnt = 0;
        end
      end else begin
        spiMiso = slavePatt[7 - monCnt];
      end
    end
    if (spiSclk !== prevSclk) sclkEdges++;
    prevSclk = spiSclk;
  end

  function automatic logic [7:0] bitrev(input logic [7:0] v);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = v[7 - i];
    return r;
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a; regRdEn = 1'b1;
    #1 d = regRdData;
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  task automatic waitIdle();
    logic [31:0] s;
    for (int i = 0; i < 1000; i++) begin
      rd(7'h64, s);
      if (s[2]) return;
    end
    chk("R7 transmit never drained", 32'd0, 32'd1);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(7'h60, v); chk("R1 control reset", v, 32'h180);
    rd(7'h64, v); chk("R1 status reset", v, 32'h25);
    chk("R1 selects high", 32'(spiSsN), 32'hF);
    chk("R1 sclk idle", 32'(spiSclk), 32'd0);
    rd(7'h74, v); chk("R13 tx occupancy empty", v, 32'd0);
    rd(7'h78, v); chk("R13 rx occupancy empty", v, 32'd0);
  endtask

  task automatic t_storage();
    logic [31:0] v;
    wr(7'h1C, 32'h8000_0000);
    wr(7'h20, 32'h0000_0155);
    wr(7'h28, 32'h0000_01FF);
    rd(7'h1C, v); chk("R14 word 0x1C", v, 32'h8000_0000);
    rd(7'h20, v); chk("R14 word 0x20", v, 32'h0000_0155);
    rd(7'h28, v); chk("R14 word 0x28", v, 32'h0000_01FF);
  endtask

  task automatic t_hold_and_run();
    logic [31:0] v;
    int e0;
    monCpol = 0; monCpha = 0;
    wr(7'h70, 32'hE);
    wr(7'h60, 32'h186);
    e0 = sclkEdges;
    wr(7'h68, 32'hABCD_125A);
    wr(7'h68, 32'h0000_01C3);
    wr(7'h68, 32'hFFFF_FF3C);
    repeat (60) @(negedge clk);
    chk("R3 no sclk edges under hold", 32'(sclkEdges - e0), 32'd0);
    rd(7'h74, v); chk("R13 tx occupancy three queued", v, 32'd2);
    rd(7'h64, v); chk("R7 tx empty clear while queued", 32'(v[2]), 32'd0);
    monNum = 0;
    wr(7'h60, 32'h087);
    repeat (6) @(negedge clk);
    rd(7'h64, v); chk("R7 tx empty clear mid burst", 32'(v[2]), 32'd0);
    waitIdle();
    rd(7'h78, v); chk("R13 rx occupancy three received", v, 32'd2);
    rd(7'h64, v); chk("R8 status after burst", v, 32'h24);
    rd(7'h6C, v); chk("R5 R8 first loopback byte", v, 32'h5A);
    rd(7'h6C, v); chk("R5 R8 second loopback byte", v, 32'hC3);
    rd(7'h6C, v); chk("R5 R8 third loopback byte", v, 32'h3C);
    chk("R4 frame count on wire", 32'(monNum), 32'd3);
    chk("R4 wire byte 0", 32'(monBytes[0]), 32'h5A);
    chk("R4 wire byte 1", 32'(monBytes[1]), 32'hC3);
    chk("R4 wire byte 2", 32'(monBytes[2]), 32'h3C);
    rd(7'h64, v); chk("R8 rx empty after drain", 32'(v[0]), 32'd1);
    wr(7'h70, 32'hF);
  endtask

  task automatic t_full_and_clear();
    logic [31:0] v;
    wr(7'h60, 32'h186);
    for (int i = 0; i < DEPTH - 1; i++) wr(7'h68, 32'(i + 1));
    rd(7'h64, v); chk("R6 not full at depth-1", 32'(v[3]), 32'd0);
    wr(7'h68, 32'h40);
    rd(7'h64, v); chk("R6 full at depth", 32'(v[3]), 32'd1);
    wr(7'h68, 32'hEE);
    wr(7'h68, 32'hEF);
    rd(7'h74, v); chk("R6 writes when full dropped", v, 32'(DEPTH - 1));
    wr(7'h60, 32'h186 | 32'h20);
    rd(7'h60, v); chk("R9 tx clear bit self clears", v, 32'h186);
    rd(7'h74, v); chk("R9 tx fifo emptied", v, 32'd0);
    rd(7'h64, v); chk("R9 tx empty after clear", 32'(v[2]), 32'd1);
    wr(7'h68, 32'h11);
    wr(7'h68, 32'h22);
    wr(7'h60, 32'h087);
    waitIdle();
    rd(7'h64, v); chk("R8 rx holds bytes", 32'(v[0]), 32'd0);
    wr(7'h60, 32'h087 | 32'h40);
    rd(7'h60, v); chk("R9 rx clear bit self clears", v, 32'h087);
    rd(7'h64, v); chk("R9 rx empty after clear", 32'(v[0]), 32'd1);
    rd(7'h78, v); chk("R9 rx occupancy after clear", v, 32'd0);
  endtask

  task automatic t_modes();
    logic [31:0] v;
    logic [7:0] patt, txb;
    logic [31:0] modeBits;
    for (int m = 0; m < 4; m++) begin
      patt = 8'hA5 + 8'(m * 23);
      txb  = 8'h5B ^ 8'(m << 4);
      modeBits = (m[0] ? 32'h08 : 32'h0) | (m[1] ? 32'h10 : 32'h0);
      monCpol = m[0]; monCpha = m[1];
      slavePatt = patt;
      wr(7'h70, 32'hF);
      wr(7'h60, 32'h186 | modeBits);
      repeat (4) @(negedge clk);
      chk($sformatf("R11 idle level mode %0d", m), 32'(spiSclk), 32'(m[0]));
      wr(7'h70, 32'hE);
      monNum = 0;
      wr(7'h68, 32'(txb));
      wr(7'h60, 32'h086 | modeBits);
      waitIdle();
      chk($sformatf("R11 wire byte mode %0d", m), 32'(monBytes[0]), 32'(txb));
      rd(7'h6C, v); chk($sformatf("R11 miso byte mode %0d", m), v, 32'(patt));
    end
    wr(7'h70, 32'hF);
  endtask

  task automatic t_lsb();
    logic [31:0] v;
    monCpol = 0; monCpha = 0;
    slavePatt = 8'hC4;
    wr(7'h70, 32'hF);
    wr(7'h60, 32'h386);
    wr(7'h70, 32'hE);
    monNum = 0;
    wr(7'h68, 32'h01);
    wr(7'h60, 32'h286);
    waitIdle();
    chk("R12 lsb first on wire", 32'(monBytes[0]), 32'(bitrev(8'h01)));
    rd(7'h6C, v); chk("R12 lsb first received", v, 32'(bitrev(8'hC4)));
    wr(7'h70, 32'hF);
    wr(7'h60, 32'h186);
  endtask

  task automatic t_select();
    logic [31:0] v;
    wr(7'h70, 32'hD);
    rd(7'h70, v); chk("R10 select register readback", v, 32'hD);
    chk("R10 manual select follows register", 32'(spiSsN), 32'hD);
    wr(7'h60, 32'h106);
    chk("R10 auto select idle high", 32'(spiSsN), 32'hF);
    wr(7'h68, 32'h77);
    wr(7'h60, 32'h007);
    repeat (6) @(negedge clk);
    chk("R10 auto select during frame", 32'(spiSsN), 32'hD);
    waitIdle();
    chk("R10 auto select after frame", 32'(spiSsN), 32'hF);
    rd(7'h6C, v); chk("R8 loopback in auto select", v, 32'h77);
  endtask

  task automatic t_soft_reset();
    logic [31:0] v;
    int e0;
    wr(7'h60, 32'h187);
    wr(7'h70, 32'hB);
    wr(7'h40, 32'h05);
    rd(7'h60, v); chk("R2 wrong key ignored control", v, 32'h187);
    chk("R2 wrong key ignored select", 32'(spiSsN), 32'hB);
    wr(7'h68, 32'h99);
    wr(7'h68, 32'h66);
    wr(7'h60, 32'h087);
    repeat (10) @(negedge clk);
    wr(7'h40, 32'h0A);
    rd(7'h60, v); chk("R2 control after key", v, 32'h180);
    chk("R2 selects after key", 32'(spiSsN), 32'hF);
    rd(7'h64, v); chk("R2 status after key", v, 32'h25);
    rd(7'h74, v); chk("R2 tx occupancy after key", v, 32'd0);
    rd(7'h78, v); chk("R2 rx occupancy after key", v, 32'd0);
    rd(7'h1C, v); chk("R2 storage cleared by key", v, 32'd0);
    e0 = sclkEdges;
    repeat (50) @(negedge clk);
    chk("R2 frame stopped", 32'(sclkEdges - e0), 32'd0);
    chk("R2 sclk idle after key", 32'(spiSclk), 32'd0);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_storage();
    t_hold_and_run();
    t_full_and_clear();
    t_modes();
    t_lsb();
    t_select();
    t_soft_reset();
    finished = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

endmodule